// File: doc/BRIEF.md
# Serial Flash Command Engine

This block is a register-driven SPI master that talks to a serial configuration flash. Software writes a 32-bit data register and then an operation register. Each operation moves one to four bytes over the serial link. In a transmit operation the bytes come out of the data register. In a receive operation the bytes are collected into the data register. While the bytes are shifting, the busy flag in the operation register stays set, and software polls it until it clears.

A continue flag in the operation word keeps chip select asserted after the operation ends. This lets software build a long flash command out of short pieces. A fast read, for example, is built in three steps:
1. A four-byte transmit that carries the command code and a 24-bit address.
2. A single dummy byte received.
3. Any number of four-byte receives.

The flash uses these command codes: 2 programs a page, 4 disables writes, 5 returns status, 6 enables writes, 11 reads data, and 216 erases a 64 KiB sector of the 512 KiB array. The engine itself treats every code as opaque data.

Top module: `sflash_cmd_engine`

## Requirements
- R1: After reset the engine is in the following state. The busy flag is clear, the operation and data read-backs are zero, chip select is high (deasserted) and the serial clock is low.
- R2: Writing the operation register (select = 1) while the engine is idle sets the busy flag (bit 31 of the operation read-back). The flag stays set for exactly 16·N·CLK_DIV clock cycles, where N is the byte count, and then clears.
- R3: An operation word with bit 0 = 1 is a transmit. Bits 2:1 hold N−1. Exactly N bytes go out on MOSI. Byte 0 of the data register (bits 7:0) goes first, and within each byte the most significant bit goes first. A transmit leaves the data register unchanged.
- R4: An operation word with bit 0 = 0 is a receive of N bytes. The first byte received lands in bits 7:0, the next in bits 15:8, and so on, with each byte assembled MSB first. Bytes above N read as zero. This is tested with the read-status command (code 5), for which the bench flash returns the byte sequence 0x3C + 17·k.
- R5: Chip select is low for the whole of every operation. Bit 3 (continue) decides what happens afterwards: when it is set, chip select stays low after the operation; when it is clear, chip select returns high as busy clears.
- R6: The link uses SPI mode 0:
  - The clock is low whenever the engine is idle.
  - Each bit takes CLK_DIV cycles low, then CLK_DIV cycles high.
  - MOSI changes only on the falling edge.
  - MISO is sampled on the rising edge.
- R7: A write to the operation register while busy is set has no effect. The running operation keeps its length, direction and continue setting, and no new operation follows.
- R8: A write to the data register while busy is set has no effect.
- R9: A flash read proceeds as follows. First, a 4-byte transmit with continue of the word {addr[7:0], addr[15:8], addr[23:16], 8'd11}. Next, a 1-byte receive with continue. Then a series of 4-byte receives, with continue set on all but the last. Each receive returns the flash bytes at addr, addr+1, and onward, with the lowest address in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 = data, 1 = operation |
| reg_wdata_i | input | 32 | Register write data |
| data_rdata_o | output | 32 | Data register read-back |
| op_rdata_o | output | 32 | Operation read-back: busy in bit 31, continue in bit 3, count−1 in bits 2:1, direction in bit 0 |
| spi_sck_o | output | 1 | Serial clock, idle low |
| spi_cs_no | output | 1 | Flash chip select, active low |
| spi_mosi_o | output | 1 | Serial data to the flash |
| spi_miso_i | input | 1 | Serial data from the flash |

## Verification
Each kind of internal error shows up at the ports in a different place and at a different time:
- A wrong bit counter or latched byte count changes the busy-high time within one operation. It also changes the number of bytes the flash model logs before chip select rises.
- A wrong index from sequence position to register bit reorders the bytes or bits. This is visible on MOSI in the same frame, or in the data read-back as soon as busy clears.
- A stale continue or chip-select state shows as a chip-select level that does not match the continue flag right after busy falls.
- Such a fault also splits or merges flash frames. The next multi-step read then returns wrong words.

// File: rtl/sf_pkg.sv
package sf_pkg;
  localparam int unsigned DATA_BYTES = 4;
  localparam int unsigned DW         = 8 * DATA_BYTES;
  localparam int unsigned CNT_W      = $clog2(DATA_BYTES);
  localparam int unsigned BIT_W      = $clog2(DW);
  localparam int unsigned BUSY_BIT   = 31;

  localparam logic SEL_DATA = 1'b0;
  localparam logic SEL_OP   = 1'b1;

  // operation word low bits: {cont, cnt_m1, tx}
  typedef struct packed {
    logic             cont;
    logic [CNT_W-1:0] cnt_m1;
    logic             tx;
  } sf_op_t;

  localparam int unsigned OP_W = $bits(sf_op_t);

  // wire order -> register bit: byte ascending, bit descending in byte
  function automatic logic [BIT_W-1:0] seq_to_bit(logic [BIT_W-1:0] seq);
    return {seq[BIT_W-1:3], ~seq[2:0]};
  endfunction
endpackage

// File: rtl/sf_clk_div.sv
module sf_clk_div #(
  parameter int unsigned DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (!run_i || cnt_q == LAST) cnt_q <= '0;
    else                              cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/sf_shift.sv
module sf_shift
  import sf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tx_i,
  input  logic [CNT_W-1:0] cnt_m1_i,
  input  logic [DW-1:0]    data_i,
  input  logic             tick_i,
  input  logic             miso_i,
  output logic             sck_o,
  output logic             mosi_o,
  output logic             active_o,
  output logic             done_o,
  output logic [DW-1:0]    rx_o
);
  logic             active_q, sck_q, mosi_q, tx_q;
  logic [BIT_W-1:0] seq_q, last_q, seq_nxt;
  logic [DW-1:0]    rx_q;

  assign seq_nxt = seq_q + 1'b1;
  assign done_o  = active_q && tick_i && sck_q && (seq_q == last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sck_q    <= 1'b0;
      mosi_q   <= 1'b0;
      tx_q     <= 1'b0;
      seq_q    <= '0;
      last_q   <= '0;
      rx_q     <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      sck_q    <= 1'b0;
      tx_q     <= tx_i;
      seq_q    <= '0;
      last_q   <= {cnt_m1_i, 3'b111};
      rx_q     <= '0;
      mosi_q   <= tx_i & data_i[seq_to_bit('0)];
    end else if (active_q && tick_i) begin
      if (!sck_q) begin
        sck_q <= 1'b1;                       // rising edge: sample
        if (!tx_q) rx_q[seq_to_bit(seq_q)] <= miso_i;
      end else begin
        sck_q <= 1'b0;                       // falling edge: advance
        if (seq_q == last_q) begin
          active_q <= 1'b0;
          mosi_q   <= 1'b0;
        end else begin
          seq_q  <= seq_nxt;
          mosi_q <= tx_q & data_i[seq_to_bit(seq_nxt)];
        end
      end
    end
  end

  assign sck_o    = sck_q;
  assign mosi_o   = mosi_q;
  assign active_o = active_q;
  assign rx_o     = rx_q;

  // R6: MOSI holds through the high phase
  a_r6_mosi_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_q && $past(sck_q)) |-> $stable(mosi_q))
    else $error("a_r6_mosi_stable_high");
endmodule

// File: rtl/sf_ctrl.sv
module sf_ctrl
  import sf_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          sel_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          done_i,
  input  logic [DW-1:0] rx_i,
  output logic          busy_o,
  output logic          cs_n_o,
  output logic          start_o,
  output sf_op_t        op_new_o,
  output sf_op_t        op_o,
  output logic [DW-1:0] data_o
);
  logic          busy_q, cs_n_q;
  sf_op_t        op_q;
  logic [DW-1:0] data_q;
  logic          start, data_wr;

  assign op_new_o = sf_op_t'(wdata_i[OP_W-1:0]);
  assign start    = wr_i && (sel_i == SEL_OP)   && !busy_q;
  assign data_wr  = wr_i && (sel_i == SEL_DATA) && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cs_n_q <= 1'b1;
      op_q   <= '0;
      data_q <= '0;
    end else begin
      if (start) begin
        busy_q <= 1'b1;
        cs_n_q <= 1'b0;
        op_q   <= op_new_o;
      end else if (done_i) begin
        busy_q <= 1'b0;
        if (!op_q.cont) cs_n_q <= 1'b1;
        if (!op_q.tx)   data_q <= rx_i;
      end
      if (data_wr) data_q <= wdata_i;
    end
  end

  assign busy_o  = busy_q;
  assign cs_n_o  = cs_n_q;
  assign start_o = start;
  assign op_o    = op_q;
  assign data_o  = data_q;

  a_r2_start_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (busy_q && !cs_n_q)) else $error("a_r2_start_sets_busy");
  a_r5_cs_low_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !cs_n_q) else $error("a_r5_cs_low_busy");
  a_r5_cs_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !op_q.cont) |=> cs_n_q) else $error("a_r5_cs_release");
  a_r5_cs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && op_q.cont) |=> !cs_n_q) else $error("a_r5_cs_hold");
  a_r7_op_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> $stable(op_q)) else $error("a_r7_op_frozen");
  a_r8_data_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> $stable(data_q)) else $error("a_r8_data_frozen");
endmodule

// File: rtl/sflash_cmd_engine.sv
module sflash_cmd_engine
  import sf_pkg::*;
#(
  parameter int unsigned CLK_DIV = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic          reg_sel_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] data_rdata_o,
  output logic [31:0]   op_rdata_o,
  output logic          spi_sck_o,
  output logic          spi_cs_no,
  output logic          spi_mosi_o,
  input  logic          spi_miso_i
);
  localparam int unsigned PAD_W = BUSY_BIT - OP_W;

  logic          busy, start, done, tick, active;
  sf_op_t        op_new, op_q;
  logic [DW-1:0] data_q, rx;

  sf_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (reg_wr_i),
    .sel_i    (reg_sel_i),
    .wdata_i  (reg_wdata_i),
    .done_i   (done),
    .rx_i     (rx),
    .busy_o   (busy),
    .cs_n_o   (spi_cs_no),
    .start_o  (start),
    .op_new_o (op_new),
    .op_o     (op_q),
    .data_o   (data_q)
  );

  sf_clk_div #(.DIV(CLK_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .tick_o (tick)
  );

  sf_shift u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .tx_i     (op_new.tx),
    .cnt_m1_i (op_new.cnt_m1),
    .data_i   (data_q),
    .tick_i   (tick),
    .miso_i   (spi_miso_i),
    .sck_o    (spi_sck_o),
    .mosi_o   (spi_mosi_o),
    .active_o (active),
    .done_o   (done),
    .rx_o     (rx)
  );

  assign data_rdata_o = data_q;
  assign op_rdata_o   = {busy, {PAD_W{1'b0}}, op_q};

  a_r6_sck_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !spi_sck_o) else $error("a_r6_sck_idle_low");
  a_r2_busy_covers_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> active) else $error("a_r2_busy_covers_shift");
endmodule

// File: tb/sflash_cmd_engine_test.sv
module sflash_cmd_engine_test;
  localparam int DIV = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        wr = 1'b0, sel = 1'b0, miso = 1'b0;
  logic [31:0] wdata = '0;
  wire  [31:0] data_rd, op_rd;
  wire         sck, cs_n, mosi;

  sflash_cmd_engine #(.CLK_DIV(DIV)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_sel_i(sel),
    .reg_wdata_i(wdata), .data_rdata_o(data_rd), .op_rdata_o(op_rd),
    .spi_sck_o(sck), .spi_cs_no(cs_n), .spi_mosi_o(mosi), .spi_miso_i(miso)
  );

  int checks = 0, fails = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(logic [23:0] a);
    return (8'(a[7:0] * 8'd29) ^ a[15:8]) ^ ({5'd0, a[18:16]} + 8'h11);
  endfunction

  function automatic logic [7:0] stat_byte(int k);
    return 8'(8'h3C + 17 * k);
  endfunction

  // flash model: mode 0 slave
  int          s_bits, s_n;
  logic [7:0]  s_sh, s_cmd;
  logic [7:0]  s_log [0:15];
  logic [23:0] s_addr;

  always @(negedge cs_n) begin
    s_bits = 0; s_n = 0; s_sh = '0; s_cmd = '0; miso = 1'b0;
  end

  always @(posedge sck) if (!cs_n) begin
    s_sh = {s_sh[6:0], mosi};
    s_bits++;
    if (s_bits % 8 == 0) begin
      if (s_n < 16) s_log[s_n] = s_sh;
      if (s_n == 0) s_cmd = s_sh;
      else if (s_n <= 3) s_addr = {s_addr[15:0], s_sh};
      s_n++;
    end
  end

  always @(negedge sck) if (!cs_n) begin : drive_miso
    logic [7:0] b;
    if (s_cmd == 8'd11 && s_bits >= 40) begin
      b = mem_byte(s_addr + 24'((s_bits - 40) / 8));
      miso = b[7 - (s_bits % 8)];
    end else if (s_cmd == 8'd5 && s_bits >= 8) begin
      b = stat_byte((s_bits - 8) / 8);
      miso = b[7 - (s_bits % 8)];
    end else begin
      miso = 1'b0;
    end
  end

  task automatic wreg(logic s, logic [31:0] v);
    @(negedge clk); wr = 1'b1; sel = s; wdata = v;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic run_op(logic cont, int nb, logic tx, logic mid, logic msel,
                        logic [31:0] mval, output int cyc);
    wreg(1'b1, {28'd0, cont, 2'(nb - 1), tx});
    cyc = 0;
    while (op_rd[31]) begin
      cyc++;
      if (mid && cyc == 3) begin wr = 1'b1; sel = msel; wdata = mval; end
      if (mid && cyc == 4) wr = 1'b0;
      @(negedge clk);
    end
    wr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    int cyc;
    logic [31:0] pat, exp;
    logic [23:0] addrs [0:3];
    addrs[0] = 24'h000000; addrs[1] = 24'h010000;
    addrs[2] = 24'h03A5C4; addrs[3] = 24'h07FFF4;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 data", data_rd, 32'h0);
    chk("R1 op", op_rd, 32'h0);
    chk("R1 cs", {31'd0, cs_n}, 32'd1);
    chk("R1 sck", {31'd0, sck}, 32'd0);

    // R2 R3 R5 R6: transmit sweep over byte counts and patterns
    for (int nb = 1; nb <= 4; nb++) begin
      for (int p = 0; p < 4; p++) begin
        pat = (32'h01234567 * (p + 1)) ^ (32'h9E3779B9 >> p) ^ {8'(nb), 24'h0};
        wreg(1'b0, pat);
        run_op(1'b0, nb, 1'b1, 1'b0, 1'b0, '0, cyc);
        chk("R2 busy cycles tx", cyc, 16 * nb * DIV);
        chk("R3 byte count", s_n, nb);
        for (int k = 0; k < nb; k++) chk("R3 byte order", {24'd0, s_log[k]}, {24'd0, pat[8*k +: 8]});
        chk("R3 data kept", data_rd, pat);
        chk("R5 cs released", {31'd0, cs_n}, 32'd1);
        chk("R6 sck idle", {31'd0, sck}, 32'd0);
      end
    end

    // R4 R5: status receive split in two pieces
    for (int a = 1; a <= 4; a++) begin
      for (int b = 1; b <= 4; b++) begin
        wreg(1'b0, 32'd5);
        run_op(1'b1, 1, 1'b1, 1'b0, 1'b0, '0, cyc);
        chk("R5 cs held", {31'd0, cs_n}, 32'd0);
        wreg(1'b0, 32'hFFFF_FFFF);
        run_op(1'b1, a, 1'b0, 1'b0, 1'b0, '0, cyc);
        exp = '0;
        for (int k = 0; k < a; k++) exp |= {24'd0, stat_byte(k)} << (8 * k);
        chk("R4 rx first", data_rd, exp);
        chk("R2 busy cycles rx", cyc, 16 * a * DIV);
        chk("R5 cs held rx", {31'd0, cs_n}, 32'd0);
        wreg(1'b0, 32'hFFFF_FFFF);
        run_op(1'b0, b, 1'b0, 1'b0, 1'b0, '0, cyc);
        exp = '0;
        for (int k = 0; k < b; k++) exp |= {24'd0, stat_byte(a + k)} << (8 * k);
        chk("R4 rx second", data_rd, exp);
        chk("R5 cs released rx", {31'd0, cs_n}, 32'd1);
      end
    end

    // R9: multi-word flash reads
    for (int i = 0; i < 4; i++) begin
      wreg(1'b0, {addrs[i][7:0], addrs[i][15:8], addrs[i][23:16], 8'd11});
      run_op(1'b1, 4, 1'b1, 1'b0, 1'b0, '0, cyc);
      run_op(1'b1, 1, 1'b0, 1'b0, 1'b0, '0, cyc);
      for (int w = 0; w < 3; w++) begin
        run_op(w < 2, 4, 1'b0, 1'b0, 1'b0, '0, cyc);
        for (int k = 0; k < 4; k++) exp[8*k +: 8] = mem_byte(addrs[i] + 24'(4 * w + k));
        chk("R9 read word", data_rd, exp);
      end
      chk("R9 cs end", {31'd0, cs_n}, 32'd1);
    end

    // R7: op write during busy ignored
    wreg(1'b0, 32'h0000_00C3);
    run_op(1'b0, 1, 1'b1, 1'b1, 1'b1, 32'h0000_000E, cyc);
    chk("R7 length kept", cyc, 16 * DIV);
    chk("R7 op kept", op_rd, 32'h0000_0001);
    chk("R7 cs released", {31'd0, cs_n}, 32'd1);
    chk("R7 one byte", s_n, 1);
    repeat (8) @(negedge clk);
    chk("R7 no new op", op_rd, 32'h0000_0001);
    chk("R7 data kept", data_rd, 32'h0000_00C3);

    // R8: data write during busy ignored
    wreg(1'b0, 32'hCAFE_F00D);
    run_op(1'b0, 2, 1'b1, 1'b1, 1'b0, 32'h1234_5678, cyc);
    chk("R8 data kept", data_rd, 32'hCAFE_F00D);
    chk("R8 byte0", {24'd0, s_log[0]}, 32'h0000_000D);
    chk("R8 byte1", {24'd0, s_log[1]}, 32'h0000_00F0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule